// File: doc/BRIEF.md
# Flash High-Voltage Operation Controller

This block holds the control word that governs program and erase operations on a flash array split into eight blocks. It also enforces the interlocks around those operations. A bus write sets four things: a mask naming the blocks to operate on, a pulse-length multiplier, a setup-lock bit that freezes the mask and multiplier, and the high-voltage request bit. The block drives one high-voltage enable per array block and a pulse-active output. The pulse-active output stays high for a programmable number of base periods. The base periods arrive from outside as single-cycle ticks.

Two external permission inputs pass through a two-sample digital filter before they are used. The first grants permission for the whole array. The second grants permission for block 0 alone. Each filtered value is frozen at the moment the high-voltage request is raised and stays frozen while the request holds. An enable input that changes during an operation therefore cannot start or stop high voltage on any block. Block 0 needs both the global permission and its own permission.

Top module: `hv_pulse_ctrl`

## Requirements
- R1: After reset the read word is all zeros. All block enables are 0 and pulse-active is 0. This means no block is selected, the multiplier field is 0 (M = 1), and the lock and request bits are clear.
- R2: The multiplier field occupies read/write bits [14:8] and is 7 bits wide. A pulse lasts M = 1 + field base-period ticks, from 1 to 128. With a tick every cycle, pulse-active stays high for exactly M cycles.
- R3: The block mask (bits [7:0]) and the multiplier change on a write only if the lock bit (bit 16) was 0 before that write. The lock bit and the request bit are always written.
- R4: Each permission input is sampled every clock. Its filtered value takes a new level only at the edge where the input equals the previous sample and differs from the current filtered value. A one-cycle glitch therefore never passes the filter.
- R5: Read bit 20 is the global permission monitor. While the request bit (bit 17) is 0, the monitor follows the filtered input one cycle later. While the request bit is 1, the monitor holds the value it had when the request was raised.
- R6: Read bit 21 is the block-0 permission monitor. It follows the same filter, capture and freeze rules as bit 20, applied to the block-0 input.
- R7: For each block n, the enable for block n is the request bit AND the global monitor AND mask bit n.
- R8: The enable for block 0 additionally requires the block-0 monitor to be 1. A set mask bit 0 gives no enable while that monitor is 0.
- R9: The write that raises the request bit loads the pulse count with M, using the multiplier value in effect after that write. Every later tick decrements the count. Pulse-active is high while the request bit is 1 and the count is non-zero. A tick in the same cycle as the raising write does not count.
- R10: Clearing the request bit drops pulse-active and all block enables in the first cycle after the write.
- R11: Read bits 15, 18, 19 and 22 to 31 always read 0, whatever value is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| rd_data | output | 32 | Register read value including both monitors |
| pe_en_in | input | 1 | Global program/erase permission input |
| b0_en_in | input | 1 | Block-0 permission input |
| base_tick | input | 1 | Single-cycle base-period tick |
| blk_hv_en | output | 8 | Per-block high-voltage enable |
| pulse_active | output | 1 | Program/erase pulse in progress |

## Verification
The bench builds the block with its default parameters: eight blocks and a 7-bit multiplier. These defaults make the full range from a one-tick pulse to the 128-tick maximum reachable when a tick arrives every cycle. With eight blocks, the random mask patterns mix block 0 against the other seven, so the block-0 veto shows up in many combinations. Random writes are combined with permission inputs that glitch and then settle. This exposes the frozen monitors both to inputs that change during an active request and to writes attempted while the lock bit is set.

// File: rtl/hv_pulse_pkg.sv
package hv_pulse_pkg;
  localparam int REG_W     = 32;
  localparam int BLK_LSB   = 0;
  localparam int MULT_LSB  = 8;
  localparam int LOCK_BIT  = 16;
  localparam int HV_BIT    = 17;
  localparam int GMON_BIT  = 20;
  localparam int B0MON_BIT = 21;
endpackage

// File: rtl/hv_ctrl_reg.sv
module hv_ctrl_reg
  import hv_pulse_pkg::*;
#(
  parameter int NUM_BLK = 8,
  parameter int MULT_W  = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  output logic [NUM_BLK-1:0] blk_sel_q,
  output logic [MULT_W-1:0]  mult_q,
  output logic [MULT_W-1:0]  mult_nx,
  output logic               lock_q,
  output logic               hv_q,
  output logic               hv_start
);
  logic [NUM_BLK-1:0] blk_nx;
  logic               lock_nx;
  logic               hv_nx;
  logic               reg_ce;

  assign reg_ce = wr_en;

  always_comb begin
    blk_nx  = blk_sel_q;
    mult_nx = mult_q;
    lock_nx = lock_q;
    hv_nx   = hv_q;
    if (wr_en) begin
      if (!lock_q) begin
        blk_nx  = wr_data[BLK_LSB +: NUM_BLK];
        mult_nx = wr_data[MULT_LSB +: MULT_W];
      end
      lock_nx = wr_data[LOCK_BIT];
      hv_nx   = wr_data[HV_BIT];
    end
  end

  assign hv_start = hv_nx & ~hv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_sel_q <= '0;
      mult_q    <= '0;
      lock_q    <= 1'b0;
      hv_q      <= 1'b0;
    end else if (reg_ce) begin
      blk_sel_q <= blk_nx;
      mult_q    <= mult_nx;
      lock_q    <= lock_nx;
      hv_q      <= hv_nx;
    end
  end
endmodule

// File: rtl/hv_en_filter.sv
module hv_en_filter (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic hv_q,
  output logic cap_q
);
  logic samp_q, filt_q;
  logic samp_nx, filt_nx, cap_nx;

  always_comb begin
    samp_nx = din;
    filt_nx = (din == samp_q) ? din : filt_q;
    cap_nx  = hv_q ? cap_q : filt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b0;
      filt_q <= 1'b0;
      cap_q  <= 1'b0;
    end else begin
      samp_q <= samp_nx;
      filt_q <= filt_nx;
      cap_q  <= cap_nx;
    end
  end
endmodule

// File: rtl/hv_pulse_timer.sv
module hv_pulse_timer #(
  parameter int MULT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hv_q,
  input  logic              hv_start,
  input  logic              base_tick,
  input  logic [MULT_W-1:0] mult_ld,
  output logic              pulse_active
);
  localparam int CNT_W = MULT_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             cnt_ce;

  assign cnt_ce = hv_start | ~hv_q | base_tick;

  always_comb begin
    cnt_nx = cnt_q;
    if (hv_start)
      cnt_nx = CNT_W'(mult_ld) + CNT_W'(1);
    else if (!hv_q)
      cnt_nx = '0;
    else if (base_tick && (cnt_q != '0))
      cnt_nx = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_ce)
      cnt_q <= cnt_nx;
  end

  assign pulse_active = hv_q & (cnt_q != '0);
endmodule

// File: rtl/hv_pulse_ctrl.sv
module hv_pulse_ctrl
  import hv_pulse_pkg::*;
#(
  parameter int NUM_BLK = 8,
  parameter int MULT_W  = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  output logic [REG_W-1:0]   rd_data,
  input  logic               pe_en_in,
  input  logic               b0_en_in,
  input  logic               base_tick,
  output logic [NUM_BLK-1:0] blk_hv_en,
  output logic               pulse_active
);
  localparam logic [REG_W-1:0] USED_MASK =
      (((REG_W'(1) << NUM_BLK) - REG_W'(1)) << BLK_LSB) |
      (((REG_W'(1) << MULT_W) - REG_W'(1)) << MULT_LSB) |
      (REG_W'(1) << LOCK_BIT) | (REG_W'(1) << HV_BIT);

  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic [NUM_BLK-1:0] blk_sel;
  logic [MULT_W-1:0]  mult_cur, mult_ld;
  logic               lock_bit, hv_bit, hv_start;
  logic               gmon, b0mon;
  logic               unused_rsv_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign unused_rsv_bits = ^(wr_data & ~USED_MASK);

  hv_ctrl_reg #(.NUM_BLK(NUM_BLK), .MULT_W(MULT_W)) u_reg (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_data(wr_data),
    .blk_sel_q(blk_sel), .mult_q(mult_cur), .mult_nx(mult_ld),
    .lock_q(lock_bit), .hv_q(hv_bit), .hv_start(hv_start)
  );

  hv_en_filter u_gflt (
    .clk(clk), .rst_n(rst_int_n), .din(pe_en_in), .hv_q(hv_bit), .cap_q(gmon)
  );

  hv_en_filter u_b0flt (
    .clk(clk), .rst_n(rst_int_n), .din(b0_en_in), .hv_q(hv_bit), .cap_q(b0mon)
  );

  hv_pulse_timer #(.MULT_W(MULT_W)) u_tmr (
    .clk(clk), .rst_n(rst_int_n), .hv_q(hv_bit), .hv_start(hv_start),
    .base_tick(base_tick), .mult_ld(mult_ld), .pulse_active(pulse_active)
  );

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk_en
    if (g == 0) begin : g_zero
      assign blk_hv_en[g] = hv_bit & gmon & b0mon & blk_sel[g];
    end else begin : g_other
      assign blk_hv_en[g] = hv_bit & gmon & blk_sel[g];
    end
  end

  always_comb begin
    rd_data                         = '0;
    rd_data[BLK_LSB +: NUM_BLK]     = blk_sel;
    rd_data[MULT_LSB +: MULT_W]     = mult_cur;
    rd_data[LOCK_BIT]               = lock_bit;
    rd_data[HV_BIT]                 = hv_bit;
    rd_data[GMON_BIT]               = gmon;
    rd_data[B0MON_BIT]              = b0mon;
  end
endmodule

// File: rtl/hv_pulse_ctrl_chk.sv
module hv_pulse_ctrl_chk
  import hv_pulse_pkg::*;
#(
  parameter int NUM_BLK = 8,
  parameter int MULT_W  = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic [REG_W-1:0]   rd_data,
  input logic [NUM_BLK-1:0] blk_hv_en,
  input logic               pulse_active
);
  localparam logic [REG_W-1:0] VISIBLE =
      (((REG_W'(1) << NUM_BLK) - REG_W'(1)) << BLK_LSB) |
      (((REG_W'(1) << MULT_W) - REG_W'(1)) << MULT_LSB) |
      (REG_W'(1) << LOCK_BIT) | (REG_W'(1) << HV_BIT) |
      (REG_W'(1) << GMON_BIT) | (REG_W'(1) << B0MON_BIT);

  AST_LOCK_HOLDS_MULT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[LOCK_BIT] |=> $stable(rd_data[MULT_LSB +: MULT_W])); // R3
  AST_LOCK_HOLDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[LOCK_BIT] |=> $stable(rd_data[BLK_LSB +: NUM_BLK])); // R3
  AST_GMON_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[HV_BIT] && $past(rd_data[HV_BIT])) |-> $stable(rd_data[GMON_BIT])); // R5
  AST_B0MON_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[HV_BIT] && $past(rd_data[HV_BIT])) |-> $stable(rd_data[B0MON_BIT])); // R6
  AST_EN_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (|blk_hv_en) |-> (rd_data[HV_BIT] && rd_data[GMON_BIT])); // R7
  AST_EN_WITHIN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_hv_en & ~rd_data[BLK_LSB +: NUM_BLK]) == '0); // R7
  AST_B0_VETO: assert property (@(posedge clk) disable iff (!rst_n)
    blk_hv_en[0] |-> rd_data[B0MON_BIT]); // R8
  AST_PULSE_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[HV_BIT]) |-> pulse_active); // R9
  AST_PULSE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_active |-> rd_data[HV_BIT]); // R10
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~VISIBLE) == '0); // R11
endmodule

bind hv_pulse_ctrl hv_pulse_ctrl_chk #(.NUM_BLK(NUM_BLK), .MULT_W(MULT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_data(rd_data),
  .blk_hv_en(blk_hv_en), .pulse_active(pulse_active)
);

// File: tb/hv_pulse_ctrl_tb.sv
module hv_pulse_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        pe_en_in = 1'b0, b0_en_in = 1'b0, base_tick = 1'b0;
  logic [7:0]  blk_hv_en;
  logic        pulse_active;

  int unsigned n_run = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  logic [7:0] m_blk; logic [6:0] m_mult; logic m_lock, m_hv;
  logic m_gs, m_gf, m_gc, m_bs, m_bf, m_bc; int m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  hv_pulse_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .pe_en_in(pe_en_in), .b0_en_in(b0_en_in), .base_tick(base_tick),
    .blk_hv_en(blk_hv_en), .pulse_active(pulse_active)
  );

  function automatic logic [31:0] exp_rd();
    logic [31:0] r = '0;
    r[7:0] = m_blk; r[14:8] = m_mult; r[16] = m_lock; r[17] = m_hv;
    r[20] = m_gc; r[21] = m_bc;
    return r;
  endfunction

  function automatic logic [7:0] exp_en();
    logic [7:0] e = {8{m_hv & m_gc}} & m_blk;
    e[0] = e[0] & m_bc;
    return e;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_blk = '0; m_mult = '0; m_lock = 0; m_hv = 0;
    m_gs = 0; m_gf = 0; m_gc = 0; m_bs = 0; m_bf = 0; m_bc = 0; m_cnt = 0;
  endtask

  // one clock: drive at negedge, advance model across posedge, compare at next negedge
  task automatic step(logic w, logic [31:0] d, logic pe, logic b0, logic tk);
    logic [7:0] n_blk; logic [6:0] n_mult; logic n_lock, n_hv;
    int n_cnt;
    wr_en = w; wr_data = d; pe_en_in = pe; b0_en_in = b0; base_tick = tk;
    n_blk = m_blk; n_mult = m_mult; n_lock = m_lock; n_hv = m_hv;
    if (w) begin
      if (!m_lock) begin n_blk = d[7:0]; n_mult = d[14:8]; end
      n_lock = d[16]; n_hv = d[17];
    end
    if (n_hv && !m_hv)  n_cnt = int'(n_mult) + 1;
    else if (!m_hv)     n_cnt = 0;
    else if (tk && m_cnt > 0) n_cnt = m_cnt - 1;
    else                n_cnt = m_cnt;
    @(posedge clk);
    m_gc = m_hv ? m_gc : m_gf;  m_bc = m_hv ? m_bc : m_bf;
    m_gf = (pe == m_gs) ? pe : m_gf;  m_bf = (b0 == m_bs) ? b0 : m_bf;
    m_gs = pe; m_bs = b0;
    m_blk = n_blk; m_mult = n_mult; m_lock = n_lock; m_hv = n_hv; m_cnt = n_cnt;
    @(negedge clk);
    wr_en = 0;
    chk("R3 R5 R6 R11 rd_data", rd_data, exp_rd());
    chk("R7 R8 blk_hv_en", {24'd0, blk_hv_en}, {24'd0, exp_en()});
    chk("R2 R9 R10 pulse_active", {31'd0, pulse_active}, {31'd0, (m_hv && m_cnt != 0)});
  endtask

  function automatic logic [31:0] cw(logic [7:0] blk, logic [6:0] mult, logic lock, logic hv);
    logic [31:0] r = '0;
    r[7:0] = blk; r[14:8] = mult; r[16] = lock; r[17] = hv;
    return r;
  endfunction

  task automatic measure_pulse(logic [6:0] mult, int exp_len);
    int len = 0;
    step(1, cw(8'h00, mult, 0, 1), 0, 0, 1);
    while (pulse_active && len < 300) begin
      len++;
      step(0, 0, 0, 0, 1);
    end
    chk("R2 pulse length", len, exp_len);
    step(1, cw(8'h00, mult, 0, 0), 0, 0, 0);
  endtask

  initial begin
    logic pe_r, b0_r;
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 rd_data in reset", rd_data, 32'd0);
    rst_n = 1'b1;
    repeat (3) step(0, 0, 0, 0, 0);
    chk("R1 reset rd_data", rd_data, 32'd0);
    chk("R1 reset enables", {24'd0, blk_hv_en}, 32'd0);
    chk("R1 reset pulse", {31'd0, pulse_active}, 32'd0);

    // R11: all-ones write, reserved bits stay zero
    step(1, 32'hFFFF_FFFF & ~32'h0002_0000 & ~32'h0001_0000, 0, 0, 0);
    chk("R11 reserved bits", rd_data & 32'hFFCC_8000, 32'd0);

    // R4 glitch rejection and settle time (request clear, monitor trails filter)
    step(1, cw(8'hFF, 0, 0, 0), 0, 0, 0);
    step(0, 0, 1, 1, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    chk("R4 glitch blocked", {31'd0, rd_data[20]}, 32'd0);
    step(0, 0, 1, 1, 0);
    step(0, 0, 1, 1, 0);
    chk("R4 R5 not yet visible", {31'd0, rd_data[20]}, 32'd0);
    step(0, 0, 1, 1, 0);
    chk("R4 R5 visible after settle", {31'd0, rd_data[20]}, 32'd1);
    chk("R6 b0 visible", {31'd0, rd_data[21]}, 32'd1);

    // R8 block 0 veto: drop b0 permission, raise request
    repeat (3) step(0, 0, 1, 0, 0);
    step(1, cw(8'hFF, 3, 0, 1), 1, 0, 0);
    chk("R8 block0 vetoed", {24'd0, blk_hv_en}, 32'hFE);
    // R5 R6 freeze: inputs swap while request held
    repeat (4) step(0, 0, 0, 1, 0);
    chk("R5 global monitor frozen", {31'd0, rd_data[20]}, 32'd1);
    chk("R6 b0 monitor frozen", {31'd0, rd_data[21]}, 32'd0);
    chk("R7 enables frozen", {24'd0, blk_hv_en}, 32'hFE);
    // R10 abort
    step(1, cw(8'hFF, 3, 0, 0), 1, 1, 0);
    chk("R10 abort enables", {24'd0, blk_hv_en}, 32'd0);
    chk("R10 abort pulse", {31'd0, pulse_active}, 32'd0);
    repeat (3) step(0, 0, 1, 1, 0);
    step(1, cw(8'h81, 40, 0, 1), 1, 1, 0);
    chk("R7 R8 all grants", {24'd0, blk_hv_en}, 32'h81);
    repeat (10) step(0, 0, 1, 1, 0);
    chk("R9 no ticks keeps pulse", {31'd0, pulse_active}, 32'd1);
    repeat (5) step(0, 0, 1, 1, 1);
    step(1, cw(8'h81, 40, 0, 0), 1, 1, 1);
    chk("R10 abort mid pulse", {31'd0, pulse_active}, 32'd0);

    // R3 lock
    step(1, cw(8'h0F, 5, 1, 0), 0, 0, 0);
    chk("R3 locking write applies", rd_data[14:0], {7'd5, 8'h0F});
    step(1, cw(8'hF0, 9, 1, 0), 0, 0, 0);
    chk("R3 locked fields kept", rd_data[14:0], {7'd5, 8'h0F});
    step(1, cw(8'hAA, 33, 0, 0), 0, 0, 0);
    chk("R3 unlock write keeps fields", rd_data[14:0], {7'd5, 8'h0F});
    chk("R3 lock bit cleared", {31'd0, rd_data[16]}, 32'd0);
    step(1, cw(8'hAA, 33, 0, 0), 0, 0, 0);
    chk("R3 unlocked write applies", rd_data[14:0], {7'd33, 8'hAA});

    // R2 extremes
    measure_pulse(7'd0, 1);
    measure_pulse(7'd127, 128);
    measure_pulse(7'd9, 10);

    // random phase
    pe_r = 0; b0_r = 0;
    for (int i = 0; i < 4000; i++) begin
      logic w; logic [31:0] d;
      w = ($urandom % 12) == 0;
      d = $urandom;
      d[16] = ($urandom % 6) == 0;
      if (($urandom % 10) == 0) pe_r = ~pe_r;
      if (($urandom % 10) == 0) b0_r = ~b0_r;
      step(w, d, pe_r ^ (($urandom % 15) == 0), b0_r ^ (($urandom % 15) == 0),
           ($urandom % 3) != 0);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule